// File: doc/BRIEF.md
# Wire-Plane Pixel Coincidence Majority

This block builds a two-dimensional picture of a wire-chamber detector from two crossing wire planes and decides whether enough of it fired. Every collection wire is paired with a sliding group of five neighbouring induction wires. A pixel is fired when the collection wire and one induction wire of its group are both active in the same snapshot. The induction signals arrive earlier than the collection signals, so each induction input is stretched over a programmable number of cycles. A late collection pulse can still meet it.

A single-cycle snapshot strobe freezes the conditioned wire states. An address generator then walks the collection wires one per cycle. Each wire's five pixels form one sector. For each sector a population count is taken and pushed into a three-deep register window. The block raises a local majority flag if any three adjacent sectors together hold at least the local threshold. It raises a global majority flag if the pixel total over the whole snapshot reaches a separate global threshold. The flags and the total are registered and held until the next scan finishes.

Top module: `wpc_majority`

## Requirements
- R1: After reset, `local_maj_o`, `global_maj_o` and `pixel_sum_o` are all zero.
- R2: A mask bit set to 1 suppresses its wire. A masked collection wire or a masked induction wire contributes no pixel.
- R3: Collection wire i forms pixels only with induction wires i through i+4. Collection wire 0 pairs with induction 4..0 and collection wire 8 pairs with induction 12..8.
- R4: An induction input is two-flop synchronised, then stays usable for coincidence for `STRETCH_CYCLES` cycles after its synchronised level drops. A new assertion reloads the full stretch. After the stretch has expired, the input forms no pixel.
- R5: The snapshot is taken on the clock edge where `flash_i` is high. Input changes after that edge do not alter the published result.
- R6: `pixel_sum_o` is published `N_COLL+1` cycles after the strobe edge. It equals the number of fired pixels in the snapshot and never exceeds `N_COLL*5`.
- R7: `local_maj_o` is 1 exactly when some group of three adjacent sectors holds a pixel count greater than or equal to `vth_i`.
- R8: `global_maj_o` is 1 exactly when the snapshot's pixel total is greater than or equal to `gth_i`.
- R9: Between publications, all three outputs hold their values regardless of input activity.
- R10: A strobe that arrives while a scan is in progress abandons that scan and restarts from sector 0 on the new snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| coll_i | input | N_COLL | Collection-wire hits (asynchronous) |
| ind_i | input | N_COLL+4 | Induction-wire hits (asynchronous) |
| coll_mask_i | input | N_COLL | 1 suppresses the matching collection wire |
| ind_mask_i | input | N_COLL+4 | 1 suppresses the matching induction wire |
| flash_i | input | 1 | Snapshot strobe, one cycle, synchronous |
| vth_i | input | clog2(3*5+1) | Local three-sector threshold |
| gth_i | input | clog2(N_COLL*5+1) | Global pixel threshold |
| local_maj_o | output | 1 | Local majority flag |
| global_maj_o | output | 1 | Whole-carpet majority flag |
| pixel_sum_o | output | clog2(N_COLL*5+1) | Total fired pixels of the last completed snapshot |

## Verification
Several properties are checked on every cycle. The outputs stay frozen except on the cycle a scan publishes. A publication is a single-cycle event, and a strobe always cancels a publication due on the next cycle. The global flag always agrees with the published total and the global threshold, and a raised local flag never comes with a total below the local threshold. Other behaviours can only be shown by the bench's scenarios against its own pixel model: the exact wire pairing, the mask effect, the stretch window edges, the snapshot freeze and the threshold boundaries.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // Scan sequencer states
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_FINAL = 2'd2
    } scan_state_e;

    // Width needed to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wpc_stretch.sv
module wpc_stretch #(
    parameter int STRETCH_CYCLES = 300
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    output logic active_o
);
    localparam int CNT_W = wpc_pkg::cnt_width(STRETCH_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } stretch_t;

    stretch_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit_i) begin
            s_d.remain = CNT_W'(STRETCH_CYCLES);
        end else if (s_q.remain != '0) begin
            s_d.remain = s_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = hit_i | (s_q.remain != '0);

endmodule

// File: rtl/wpc_input_cond.sv
module wpc_input_cond #(
    parameter int N_COLL         = 9,
    parameter int GROUP          = 5,
    parameter int STRETCH_CYCLES = 300
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_COLL-1:0]       coll_i,
    input  logic [N_COLL+GROUP-2:0] ind_i,
    input  logic [N_COLL-1:0]       coll_mask_i,
    input  logic [N_COLL+GROUP-2:0] ind_mask_i,
    output logic [N_COLL-1:0]       coll_live_o,
    output logic [N_COLL+GROUP-2:0] ind_live_o
);
    localparam int N_IND = N_COLL + GROUP - 1;

    typedef struct packed {
        logic [N_COLL-1:0] coll_m;
        logic [N_COLL-1:0] coll_s;
        logic [N_IND-1:0]  ind_m;
        logic [N_IND-1:0]  ind_s;
    } sync_t;

    sync_t y_d, y_q;
    logic [N_IND-1:0] ind_hit;

    always_comb begin
        y_d        = y_q;
        y_d.coll_m = coll_i;
        y_d.coll_s = y_q.coll_m;
        y_d.ind_m  = ind_i;
        y_d.ind_s  = y_q.ind_m;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            y_q <= '0;
        end else begin
            y_q <= y_d;
        end
    end

    assign coll_live_o = y_q.coll_s & ~coll_mask_i;
    assign ind_hit     = y_q.ind_s & ~ind_mask_i;

    for (genvar w = 0; w < N_IND; w++) begin : g_stretch
        wpc_stretch #(
            .STRETCH_CYCLES(STRETCH_CYCLES)
        ) u_stretch (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .hit_i   (ind_hit[w]),
            .active_o(ind_live_o[w])
        );
    end

endmodule

// File: rtl/wpc_sector_scan.sv
module wpc_sector_scan #(
    parameter int N_COLL = 9,
    parameter int GROUP  = 5,
    parameter int WIN    = 3
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic                                        start_i,
    input  logic [N_COLL-1:0][GROUP-1:0]                pix_i,
    input  logic [wpc_pkg::cnt_width(WIN*GROUP)-1:0]    vth_i,
    input  logic [wpc_pkg::cnt_width(N_COLL*GROUP)-1:0] gth_i,
    output logic                                        local_maj_o,
    output logic                                        global_maj_o,
    output logic [wpc_pkg::cnt_width(N_COLL*GROUP)-1:0] sum_o,
    output logic                                        pub_o
);
    import wpc_pkg::*;

    localparam int SECT_W = cnt_width(GROUP);
    localparam int WSUM_W = cnt_width(WIN * GROUP);
    localparam int TOT_W  = cnt_width(N_COLL * GROUP);
    localparam int ADDR_W = cnt_width(N_COLL - 1);
    localparam int FILL_W = cnt_width(N_COLL);

    typedef struct packed {
        scan_state_e                  st;
        logic [ADDR_W-1:0]            addr;
        logic [FILL_W-1:0]            filled;
        logic [WIN-1:0][SECT_W-1:0]   win;
        logic [TOT_W-1:0]             total;
        logic                         hit;
        logic                         local_maj;
        logic                         global_maj;
        logic [TOT_W-1:0]             sum;
    } scan_t;

    scan_t r_d, r_q;
    logic [SECT_W-1:0] sect_cnt;
    logic [WSUM_W-1:0] win_sum;
    logic              win_full;
    logic              win_hit;

    // Encoder: fired pixels inside the addressed sector
    always_comb begin
        sect_cnt = '0;
        for (int j = 0; j < GROUP; j++) begin
            sect_cnt = sect_cnt + SECT_W'(pix_i[r_q.addr][j]);
        end
    end

    // Sum across the adjacent-sector window
    always_comb begin
        win_sum = '0;
        for (int k = 0; k < WIN; k++) begin
            win_sum = win_sum + WSUM_W'(r_q.win[k]);
        end
    end

    assign win_full = (r_q.filled >= FILL_W'(WIN));
    assign win_hit  = win_full && (win_sum >= vth_i);

    always_comb begin
        r_d   = r_q;
        pub_o = 1'b0;
        unique case (r_q.st)
            SC_SCAN: begin
                r_d.win[0] = sect_cnt;
                for (int k = 1; k < WIN; k++) begin
                    r_d.win[k] = r_q.win[k-1];
                end
                r_d.total  = r_q.total + TOT_W'(sect_cnt);
                r_d.filled = r_q.filled + 1'b1;
                r_d.addr   = r_q.addr + 1'b1;
                if (win_hit) begin
                    r_d.hit = 1'b1;
                end
                if (r_q.addr == ADDR_W'(N_COLL - 1)) begin
                    r_d.st = SC_FINAL;
                end
            end
            SC_FINAL: begin
                r_d.local_maj  = r_q.hit | win_hit;
                r_d.global_maj = (r_q.total >= gth_i);
                r_d.sum        = r_q.total;
                r_d.st         = SC_IDLE;
                pub_o          = 1'b1;
            end
            default: begin
                r_d.st = SC_IDLE;
            end
        endcase
        if (start_i) begin
            r_d.st     = SC_SCAN;
            r_d.addr   = '0;
            r_d.filled = '0;
            r_d.total  = '0;
            r_d.hit    = 1'b0;
            pub_o      = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= SC_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign local_maj_o  = r_q.local_maj;
    assign global_maj_o = r_q.global_maj;
    assign sum_o        = r_q.sum;

endmodule

// File: rtl/wpc_majority.sv
module wpc_majority #(
    parameter int N_COLL         = 9,
    parameter int STRETCH_CYCLES = 300
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic [N_COLL-1:0]                       coll_i,
    input  logic [N_COLL+3:0]                       ind_i,
    input  logic [N_COLL-1:0]                       coll_mask_i,
    input  logic [N_COLL+3:0]                       ind_mask_i,
    input  logic                                    flash_i,
    input  logic [wpc_pkg::cnt_width(15)-1:0]       vth_i,
    input  logic [wpc_pkg::cnt_width(N_COLL*5)-1:0] gth_i,
    output logic                                    local_maj_o,
    output logic                                    global_maj_o,
    output logic [wpc_pkg::cnt_width(N_COLL*5)-1:0] pixel_sum_o
);
    localparam int GROUP = 5;
    localparam int WIN   = 3;
    localparam int N_IND = N_COLL + GROUP - 1;

    typedef struct packed {
        logic [N_COLL-1:0] coll;
        logic [N_IND-1:0]  ind;
    } snap_t;

    snap_t sn_d, sn_q;
    logic [N_COLL-1:0]            coll_live;
    logic [N_IND-1:0]             ind_live;
    logic [N_COLL-1:0][GROUP-1:0] pix;
    logic                         scan_pub;

    wpc_input_cond #(
        .N_COLL        (N_COLL),
        .GROUP         (GROUP),
        .STRETCH_CYCLES(STRETCH_CYCLES)
    ) u_cond (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .coll_i     (coll_i),
        .ind_i      (ind_i),
        .coll_mask_i(coll_mask_i),
        .ind_mask_i (ind_mask_i),
        .coll_live_o(coll_live),
        .ind_live_o (ind_live)
    );

    // Snapshot of the conditioned planes
    always_comb begin
        sn_d = sn_q;
        if (flash_i) begin
            sn_d.coll = coll_live;
            sn_d.ind  = ind_live;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sn_q <= '0;
        end else begin
            sn_q <= sn_d;
        end
    end

    // Coincidence matrix: collection wire c against induction c .. c+GROUP-1
    for (genvar c = 0; c < N_COLL; c++) begin : g_row
        assign pix[c] = {GROUP{sn_q.coll[c]}} & sn_q.ind[c +: GROUP];
    end

    wpc_sector_scan #(
        .N_COLL(N_COLL),
        .GROUP (GROUP),
        .WIN   (WIN)
    ) u_scan (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (flash_i),
        .pix_i       (pix),
        .vth_i       (vth_i),
        .gth_i       (gth_i),
        .local_maj_o (local_maj_o),
        .global_maj_o(global_maj_o),
        .sum_o       (pixel_sum_o),
        .pub_o       (scan_pub)
    );

endmodule

// File: rtl/wpc_majority_chk.sv
module wpc_majority_chk #(
    parameter int N_COLL = 9
) (
    input logic                                    clk_i,
    input logic                                    rst_ni,
    input logic                                    flash_i,
    input logic                                    scan_pub,
    input logic [wpc_pkg::cnt_width(15)-1:0]       vth_i,
    input logic [wpc_pkg::cnt_width(N_COLL*5)-1:0] gth_i,
    input logic                                    local_maj_o,
    input logic                                    global_maj_o,
    input logic [wpc_pkg::cnt_width(N_COLL*5)-1:0] pixel_sum_o
);
    localparam int MAX_PIX = N_COLL * 5;

    assert_sum_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(pixel_sum_o) <= MAX_PIX);

    assert_single_pub_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_pub |=> !scan_pub);

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !scan_pub |=> ($stable(local_maj_o) && $stable(global_maj_o) && $stable(pixel_sum_o)));

    assert_global_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_pub |=> (global_maj_o == (pixel_sum_o >= $past(gth_i))));

    assert_local_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_pub |=> (!local_maj_o || int'(pixel_sum_o) >= int'($past(vth_i))));

    assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flash_i |=> !scan_pub);

endmodule

bind wpc_majority wpc_majority_chk #(
    .N_COLL(N_COLL)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flash_i     (flash_i),
    .scan_pub    (scan_pub),
    .vth_i       (vth_i),
    .gth_i       (gth_i),
    .local_maj_o (local_maj_o),
    .global_maj_o(global_maj_o),
    .pixel_sum_o (pixel_sum_o)
);

// File: tb/wpc_majority_test.sv
module wpc_majority_test;
    localparam int NC = 9;
    localparam int NI = NC + 4;
    localparam int ST = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] coll = '0;
    logic [NI-1:0] ind = '0;
    logic [NC-1:0] cmask = '0;
    logic [NI-1:0] imask = '0;
    logic          flash = 1'b0;
    logic [3:0]    vth = '0;
    logic [5:0]    gth = '0;
    logic          loc_o, glo_o;
    logic [5:0]    sum_o;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wpc_majority #(.N_COLL(NC), .STRETCH_CYCLES(ST)) uut (
        .clk_i(clk), .rst_ni(rst_n), .coll_i(coll), .ind_i(ind),
        .coll_mask_i(cmask), .ind_mask_i(imask), .flash_i(flash),
        .vth_i(vth), .gth_i(gth), .local_maj_o(loc_o),
        .global_maj_o(glo_o), .pixel_sum_o(sum_o)
    );

    function automatic void model(input logic [NC-1:0] c, input logic [NI-1:0] n,
                                  input int lth, input int gt,
                                  output int s, output bit l, output bit g);
        int sect[NC];
        s = 0;
        for (int i = 0; i < NC; i++) begin
            sect[i] = 0;
            for (int j = 0; j < 5; j++)
                if (c[i] && n[i+j]) sect[i]++;
            s += sect[i];
        end
        l = 1'b0;
        for (int i = 0; i + 2 < NC; i++)
            if (sect[i] + sect[i+1] + sect[i+2] >= lth) l = 1'b1;
        g = (s >= gt);
    endfunction

    task automatic check(input string tag, input int es, input bit el, input bit eg);
        vectors++;
        if (int'(sum_o) != es || loc_o != el || glo_o != eg) begin
            fails++;
            $display("FAIL %s: sum/local/global got %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, sum_o, loc_o, glo_o, es, el, eg);
        end
    endtask

    task automatic pulse_flash();
        flash = 1'b1;
        @(negedge clk);
        flash = 1'b0;
    endtask

    task automatic run(input string tag, input logic [NC-1:0] c, input logic [NI-1:0] n,
                       input logic [NC-1:0] cm, input logic [NI-1:0] im,
                       input int lth, input int gt);
        int s; bit l, g;
        coll = c; ind = n; cmask = cm; imask = im;
        vth = 4'(lth); gth = 6'(gt);
        repeat (ST + 6) @(negedge clk);
        pulse_flash();
        repeat (NC + 3) @(negedge clk);
        model(c & ~cm, n & ~im, lth, gt, s, l, g);
        check(tag, s, l, g);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int s; bit l, g;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 0, 1'b0, 1'b0);

        // R3 pairing extremes
        run("R3 c0-i4", 9'h001, 13'h0010, '0, '0, 1, 1);
        run("R3 c8-i12", 9'h100, 13'h1000, '0, '0, 1, 1);
        run("R3 c8-i7", 9'h100, 13'h0080, '0, '0, 1, 1);
        run("R3 c0-i5", 9'h001, 13'h0020, '0, '0, 1, 1);

        // R2 masks
        run("R2 coll mask", 9'h1FF, 13'h1FFF, 9'h1FE, '0, 15, 45);
        run("R2 ind mask", 9'h1FF, 13'h1FFF, '0, 13'h1FFF, 1, 1);

        // R7 / R8 threshold boundaries: sectors 5,0,5 total 10
        run("R7 vth equal", 9'h005, 13'h1FFF, '0, '0, 10, 10);
        run("R7 vth above", 9'h005, 13'h1FFF, '0, '0, 11, 11);
        run("R8 full carpet", 9'h1FF, 13'h1FFF, '0, '0, 15, 45);

        // R4 stretch inside and outside the window
        coll = 9'h001; ind = 13'h0010; cmask = '0; imask = '0; vth = 4'd1; gth = 6'd1;
        repeat (ST + 6) @(negedge clk);
        ind = '0;
        repeat (3) @(negedge clk);
        pulse_flash();
        repeat (NC + 3) @(negedge clk);
        check("R4 inside stretch", 1, 1'b1, 1'b1);
        ind = 13'h0010;
        repeat (ST + 6) @(negedge clk);
        ind = '0;
        repeat (ST + 12) @(negedge clk);
        pulse_flash();
        repeat (NC + 3) @(negedge clk);
        check("R4 after stretch", 0, 1'b0, 1'b0);

        // R5 snapshot frozen against later input changes
        coll = 9'h003; ind = 13'h003F; vth = 4'd8; gth = 6'd9;
        repeat (ST + 6) @(negedge clk);
        pulse_flash();
        coll = 9'h1FF; ind = 13'h1FFF;
        repeat (NC + 3) @(negedge clk);
        model(9'h003, 13'h003F, 8, 9, s, l, g);
        check("R5 snapshot", s, l, g);

        // R9 outputs hold without a strobe
        coll = '0; ind = '0;
        repeat (30) @(negedge clk);
        check("R9 hold", s, l, g);

        // R10 restart mid-scan
        coll = 9'h1FF; ind = 13'h1FFF; vth = 4'd15; gth = 6'd6;
        repeat (ST + 6) @(negedge clk);
        pulse_flash();
        coll = 9'h001;
        repeat (4) @(negedge clk);
        pulse_flash();
        repeat (NC + 3) @(negedge clk);
        check("R10 restart", 5, 1'b0, 1'b0);

        // R6 / R7 / R8 random patterns
        for (int v = 0; v < 200; v++) begin
            logic [NC-1:0] c;
            logic [NI-1:0] n, im;
            logic [NC-1:0] cm;
            c  = NC'($urandom);
            n  = NI'($urandom);
            if (v % 3 == 0) begin
                c = c & NC'($urandom);
                n = n & NI'($urandom);
            end
            cm = (v % 4 == 0) ? NC'($urandom & $urandom) : '0;
            im = (v % 5 == 0) ? NI'($urandom & $urandom) : '0;
            run("R6 R7 R8 random", c, n, cm, im, int'($urandom_range(15, 0)),
                int'($urandom_range(45, 0)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule